// File: doc/BRIEF.md
# System-Management Interrupt Status Register Pair

This block gathers the system-management interrupt sources of a chip into two 8-bit status registers. A host reads them over a simple I/O register bus. The first register sits at the programmable power-management base plus 12h, and the second at base plus 13h. An access to any other address returns zero.

The bits do not all clear in the same way. Mouse, keyboard, keyboard-controller port line, parallel port, both UARTs, floppy controller, the two group interrupts and the watchdog are live levels. Each follows its source, and only the source can clear it. Three bits are sticky flags that a read of the first register clears:
- an auxiliary event flag;
- a sleep-enable write flag;
- an infrared activity flag. This flag is set by any edge on whichever of two infrared receive pins a configuration bit selects.

A combined SMI request output is high while any status bit that has its enable bit set is 1.

The infrared pins are first passed through a two-flop synchronizer. A small state machine then controls the edge detector. The states are:
- `IR_FILL`: flushes the synchronizer after reset.
- `IR_PRIME`: loads the reference sample.
- `IR_WATCH`: compares each new sample with the previous one.

The transitions are:
- reset → `IR_FILL`.
- `IR_FILL` → `IR_PRIME` once the synchronizer is full.
- `IR_PRIME` → `IR_WATCH` after one cycle.
- `IR_WATCH` → `IR_WATCH` from then on.

While in `IR_WATCH`, a cycle in which the selector changes is ignored, so switching between the pins does not set the flag.

Top module: `smi_status_pair`

## Requirements
- R1: After reset with all sources low, a read at base+12h and a read at base+13h each return 00h, and all sticky flags are clear.
- R2: `rd_data` is zero when `rd_stb` is low, and zero during a strobe whose address is neither base+12h nor base+13h.
- R3: At base+12h, bit 0 = mouse, bit 1 = keyboard and bit 4 = keyboard-controller port line. Each follows its input level, and a read does not clear it.
- R4: At base+13h, the bits are: bit 1 parallel port, bit 2 UART 2, bit 3 UART 1, bit 4 floppy, bit 5 group 2, bit 6 group 1, bit 7 watchdog. Each is a live level, and bit 0 always reads 0.
- R5: Bit 2 of base+12h is set by a rising or a falling change of the selected infrared pin, no later than the third rising clock edge after the change. The rising edge that ends a strobe at base+12h clears it.
- R6: `ir_sel`=0 selects `ir_rx_a` and `ir_sel`=1 selects `ir_rx_b`. Changes on the unselected pin have no effect, and changing `ir_sel` does not set bit 2.
- R7: Bit 3 of base+12h is set by an `aux_evt` pulse, holds until read, and is cleared by a read at base+12h.
- R8: Bit 7 of base+12h is set by a `sleep_wr_evt` pulse, holds until read, and is cleared by a read at base+12h.
- R9: A sticky flag whose set event arrives in the same cycle as the clearing read stays set for the next read.
- R10: Bits 5 and 6 of base+12h always read 0.
- R11: `smi_req` equals the OR of (status1 & `smi_en1`) and (status2 & `smi_en2`), where the bit positions are those of R3–R8.
- R12: An infrared pin level that is already present when reset is released does not set bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous battery-domain power-on reset |
| pm_base | input | 16 | Power-management I/O base address |
| io_addr | input | 16 | I/O read address |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_data | output | 8 | Combinational read data |
| mouse_irq | input | 1 | Mouse interrupt level |
| kbd_irq | input | 1 | Keyboard interrupt level |
| kbc_p12 | input | 1 | Keyboard-controller port line level |
| aux_evt | input | 1 | Auxiliary event pulse (sets bit 3) |
| sleep_wr_evt | input | 1 | Pulse when the sleep-enable bit is written to 1 |
| ir_rx_a | input | 1 | Infrared receive pin A (asynchronous) |
| ir_rx_b | input | 1 | Infrared receive pin B (asynchronous) |
| ir_sel | input | 1 | Infrared pin select: 0 selects A, 1 selects B |
| par_irq | input | 1 | Parallel port interrupt level |
| uart2_irq | input | 1 | UART 2 interrupt level |
| uart1_irq | input | 1 | UART 1 interrupt level |
| fdc_irq | input | 1 | Floppy controller interrupt level |
| grp2_irq | input | 1 | Group interrupt 2 level |
| grp1_irq | input | 1 | Group interrupt 1 level |
| wdt_irq | input | 1 | Watchdog interrupt level |
| smi_en1 | input | 8 | Per-bit SMI enable for status register 1 |
| smi_en2 | input | 8 | Per-bit SMI enable for status register 2 |
| smi_req | output | 1 | Combined SMI request |

## Verification
Reads are tried with these patterns:
- single live sources, combined live sources, and reads repeated with a source held;
- reads at neighbouring addresses below and above the pair.

These separate live bits from sticky bits and confirm the decode window. Each sticky flag is pulsed and then read twice, which shows set-until-read followed by clear.

The infrared detector is exercised with:
- a rising and a falling change on the selected pin;
- a change on the unselected pin;
- a selector switch while the two pins differ;
- a pin held high through reset.

These tell a genuine edge apart from mux artefacts and reset artefacts. A set event placed in the same cycle as the clearing read checks that the event survives. Enable masks applied to single sources check the request combining.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int STS_W      = 8;
    localparam int OFS_STS1   = 'h12;
    localparam int OFS_STS2   = 'h13;

    // status register 1 bit positions
    localparam int B1_MOUSE   = 0;
    localparam int B1_KBD     = 1;
    localparam int B1_IR      = 2;
    localparam int B1_AUX     = 3;
    localparam int B1_P12     = 4;
    localparam int B1_SLEEP   = 7;

    // sticky flag indices
    localparam int N_STICKY   = 3;
    localparam int SF_IR      = 0;
    localparam int SF_AUX     = 1;
    localparam int SF_SLEEP   = 2;

    typedef enum logic [1:0] {
        IR_FILL  = 2'd0,
        IR_PRIME = 2'd1,
        IR_WATCH = 2'd2
    } ir_state_t;
endpackage

// File: rtl/smi_ir_edge.sv
module smi_ir_edge
    import smi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a,
    input  logic pin_b,
    input  logic sel,
    output logic edge_o
);
    localparam int CNT_W     = $clog2(SYNC_STAGES + 1);
    localparam int FILL_LAST = SYNC_STAGES - 1;

    logic [1:0]             pins;
    logic [1:0]             synced;
    logic [SYNC_STAGES-1:0] sync_q [2];
    logic                   mux_s;
    logic                   prev_q;
    logic                   sel_q;
    logic [CNT_W-1:0]       cnt_q;
    ir_state_t              state_q, state_d;

    assign pins = {pin_b, pin_a};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= '0;
                else        sync_q[g] <= {sync_q[g][SYNC_STAGES-2:0], pins[g]};
            end
            assign synced[g] = sync_q[g][SYNC_STAGES-1];
        end
    endgenerate

    assign mux_s = sel ? synced[1] : synced[0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IR_FILL:  if (cnt_q == CNT_W'(FILL_LAST)) state_d = IR_PRIME;
            IR_PRIME: state_d = IR_WATCH;
            IR_WATCH: state_d = IR_WATCH;
            default:  state_d = IR_FILL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IR_FILL;
            cnt_q   <= '0;
            prev_q  <= 1'b0;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= mux_s;
            sel_q   <= sel;
            if (state_q == IR_FILL) cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        edge_o = 1'b0;
        unique case (state_q)
            IR_FILL, IR_PRIME: edge_o = 1'b0;
            IR_WATCH:          edge_o = (sel == sel_q) && (mux_s != prev_q);
            default:           edge_o = 1'b0;
        endcase
    end

    assert_watch_stays_R12: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == IR_WATCH |=> state_q == IR_WATCH);
    assert_sel_switch_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> !edge_o);
endmodule

// File: rtl/smi_sticky_flag.sv
module smi_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    assert_hold_until_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/smi_reg_decode.sv
module smi_reg_decode
    import smi_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pm_base,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              rd_stb,
    input  logic [STS_W-1:0]  sts1,
    input  logic [STS_W-1:0]  sts2,
    output logic              hit1,
    output logic [STS_W-1:0]  rd_data
);
    logic hit2;

    assign hit1 = rd_stb && (io_addr == pm_base + ADDR_W'(OFS_STS1));
    assign hit2 = rd_stb && (io_addr == pm_base + ADDR_W'(OFS_STS2));

    always_comb begin
        rd_data = '0;
        if (hit1)      rd_data = sts1;
        else if (hit2) rd_data = sts2;
    end

    assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |-> rd_data == '0);
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit1 |-> rd_data[6:5] == 2'b00);
endmodule

// File: rtl/smi_status_pair.sv
module smi_status_pair
    import smi_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pm_base,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              rd_stb,
    output logic [STS_W-1:0]  rd_data,
    input  logic              mouse_irq,
    input  logic              kbd_irq,
    input  logic              kbc_p12,
    input  logic              aux_evt,
    input  logic              sleep_wr_evt,
    input  logic              ir_rx_a,
    input  logic              ir_rx_b,
    input  logic              ir_sel,
    input  logic              par_irq,
    input  logic              uart2_irq,
    input  logic              uart1_irq,
    input  logic              fdc_irq,
    input  logic              grp2_irq,
    input  logic              grp1_irq,
    input  logic              wdt_irq,
    input  logic [STS_W-1:0]  smi_en1,
    input  logic [STS_W-1:0]  smi_en2,
    output logic              smi_req
);
    logic                ir_edge;
    logic                hit1;
    logic [N_STICKY-1:0] flag_set;
    logic [N_STICKY-1:0] flag_q;
    logic [STS_W-1:0]    sts1;
    logic [STS_W-1:0]    sts2;

    smi_ir_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ir (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_a  (ir_rx_a),
        .pin_b  (ir_rx_b),
        .sel    (ir_sel),
        .edge_o (ir_edge)
    );

    assign flag_set[SF_IR]    = ir_edge;
    assign flag_set[SF_AUX]   = aux_evt;
    assign flag_set[SF_SLEEP] = sleep_wr_evt;

    generate
        for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
            smi_sticky_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (flag_set[i]),
                .clr_i  (hit1),
                .flag_o (flag_q[i])
            );
        end
    endgenerate

    always_comb begin
        sts1           = '0;
        sts1[B1_MOUSE] = mouse_irq;
        sts1[B1_KBD]   = kbd_irq;
        sts1[B1_IR]    = flag_q[SF_IR];
        sts1[B1_AUX]   = flag_q[SF_AUX];
        sts1[B1_P12]   = kbc_p12;
        sts1[B1_SLEEP] = flag_q[SF_SLEEP];
    end

    assign sts2 = {wdt_irq, grp1_irq, grp2_irq, fdc_irq,
                   uart1_irq, uart2_irq, par_irq, 1'b0};

    smi_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .pm_base (pm_base),
        .io_addr (io_addr),
        .rd_stb  (rd_stb),
        .sts1    (sts1),
        .sts2    (sts2),
        .hit1    (hit1),
        .rd_data (rd_data)
    );

    assign smi_req = |{sts1 & smi_en1, sts2 & smi_en2};

    assert_reg2_bit0_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && io_addr == pm_base + ADDR_W'(OFS_STS2)) |-> !rd_data[0]);
    assert_req_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_en1 == '0 && smi_en2 == '0) |-> !smi_req);
endmodule

// File: tb/smi_status_pair_bench.sv
module smi_status_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pm_base = 16'h0400;
    logic [15:0] io_addr = '0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_data;
    logic mouse_irq = 0, kbd_irq = 0, kbc_p12 = 0, aux_evt = 0, sleep_wr_evt = 0;
    logic ir_rx_a = 1, ir_rx_b = 0, ir_sel = 0;
    logic par_irq = 0, uart2_irq = 0, uart1_irq = 0, fdc_irq = 0;
    logic grp2_irq = 0, grp1_irq = 0, wdt_irq = 0;
    logic [7:0] smi_en1 = '0, smi_en2 = '0;
    logic       smi_req;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;
    logic [7:0] q_exp [$];
    string      q_tag [$];

    always #5 clk = ~clk;

    smi_status_pair u_smi_status_pair (.*);

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: one-cycle read strobe, expected value into scoreboard
    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        io_addr = a; rd_stb = 1'b1;
        q_exp.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic pulse_aux();
        @(negedge clk); aux_evt = 1'b1;
        @(negedge clk); aux_evt = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk); sleep_wr_evt = 1'b1;
        @(negedge clk); sleep_wr_evt = 1'b0;
    endtask

    task automatic chk_req(input logic exp, input string tag);
        @(negedge clk); #2;
        chk(smi_req === exp, tag, {7'd0, smi_req}, {7'd0, exp});
    endtask

    // monitor: compare read data while the strobe is high
    always begin
        @(negedge clk); #2;
        if (rd_stb) begin
            if (q_exp.size() == 0) chk(1'b0, "R2 unexpected read", rd_data, 8'h00);
            else begin
                logic [7:0] e;
                string t;
                e = q_exp.pop_front(); t = q_tag.pop_front();
                chk(rd_data === e, t, rd_data, e);
            end
        end
    end

    initial begin
        #1_000_000;
        chk(1'b0, "watchdog", 8'h00, 8'h00);
        report();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(6);
        // R1 / R12: pin A held high through reset must not flag
        rd(16'h0412, 8'h00, "R1 R12 sts1 after reset");
        rd(16'h0413, 8'h00, "R1 sts2 after reset");
        chk_req(1'b0, "R11 idle request");
        // R2 decode window
        mouse_irq = 1; par_irq = 1;
        rd(16'h0411, 8'h00, "R2 below window");
        rd(16'h0414, 8'h00, "R2 above window");
        @(negedge clk); #2;
        chk(rd_data === 8'h00, "R2 no strobe", rd_data, 8'h00);
        par_irq = 0;
        // R3 live bits
        kbd_irq = 1; kbc_p12 = 1;
        rd(16'h0412, 8'h13, "R3 live bits");
        rd(16'h0412, 8'h13, "R3 not cleared by read");
        mouse_irq = 0; kbd_irq = 0; kbc_p12 = 0;
        rd(16'h0412, 8'h00, "R3 follows source");
        // R4 register 2
        par_irq = 1;
        rd(16'h0413, 8'h02, "R4 parallel bit1");
        uart2_irq = 1; uart1_irq = 1; fdc_irq = 1; grp2_irq = 1; grp1_irq = 1; wdt_irq = 1;
        rd(16'h0413, 8'hFE, "R4 all sources");
        uart2_irq = 0; uart1_irq = 0; grp2_irq = 0; grp1_irq = 0;
        rd(16'h0413, 8'h92, "R4 par fdc wdt");
        par_irq = 0; fdc_irq = 0; wdt_irq = 0;
        rd(16'h0413, 8'h00, "R4 cleared at source");
        // R7 aux flag
        pulse_aux();
        rd(16'h0412, 8'h08, "R7 aux set");
        rd(16'h0412, 8'h00, "R7 aux cleared by read");
        // R8 sleep flag
        pulse_sleep();
        tick(2);
        rd(16'h0412, 8'h80, "R8 sleep set held");
        rd(16'h0412, 8'h00, "R8 sleep cleared by read");
        // R5 infrared edges on pin A
        @(negedge clk); ir_rx_a = 0;
        tick(4);
        rd(16'h0412, 8'h04, "R5 falling edge");
        rd(16'h0412, 8'h00, "R5 cleared by read");
        @(negedge clk); ir_rx_a = 1;
        tick(4);
        rd(16'h0412, 8'h04, "R5 rising edge");
        rd(16'h0412, 8'h00, "R5 cleared again");
        // R6 unselected pin and selector switch
        @(negedge clk); ir_rx_b = 1;
        tick(4);
        @(negedge clk); ir_rx_b = 0;
        tick(4);
        rd(16'h0412, 8'h00, "R6 unselected pin ignored");
        @(negedge clk); ir_sel = 1;
        tick(4);
        rd(16'h0412, 8'h00, "R6 select switch no flag");
        @(negedge clk); ir_rx_b = 1;
        tick(4);
        rd(16'h0412, 8'h04, "R6 pin B selected");
        rd(16'h0412, 8'h00, "R6 cleared");
        // R9 set in the same cycle as the clearing read
        @(negedge clk);
        io_addr = 16'h0412; rd_stb = 1; aux_evt = 1;
        q_exp.push_back(8'h00); q_tag.push_back("R9 read during set");
        @(negedge clk);
        rd_stb = 0; aux_evt = 0;
        rd(16'h0412, 8'h08, "R9 set survives read");
        rd(16'h0412, 8'h00, "R9 cleared afterwards");
        // R10 reserved bits with everything set
        mouse_irq = 1; kbd_irq = 1; kbc_p12 = 1;
        pulse_aux(); pulse_sleep();
        @(negedge clk); ir_rx_b = 0;
        tick(4);
        rd(16'h0412, 8'h9F, "R10 reserved bits zero");
        mouse_irq = 0; kbd_irq = 0; kbc_p12 = 0;
        rd(16'h0412, 8'h00, "R10 all clear");
        // R11 request combining
        mouse_irq = 1;
        chk_req(1'b0, "R11 masked mouse");
        smi_en1 = 8'h01;
        chk_req(1'b1, "R11 enabled mouse");
        mouse_irq = 0; wdt_irq = 1; smi_en2 = 8'h7F;
        chk_req(1'b0, "R11 masked watchdog");
        smi_en2 = 8'h80;
        chk_req(1'b1, "R11 enabled watchdog");
        wdt_irq = 0; smi_en1 = 8'h08;
        pulse_aux();
        chk_req(1'b1, "R11 sticky aux request");
        rd(16'h0412, 8'h08, "R11 aux read");
        chk_req(1'b0, "R11 request drops after read");
        tick(4);
        report();
    end
endmodule